// File: doc/BRIEF.md
# Static Backward-Taken Branch Direction Predictor

This block sits beside the fetch stage of a five-stage in-order pipeline that resolves conditional branches in decode. Each cycle it looks at a pre-decode class of the instruction being fetched and, for a conditional branch, at the sign bit of its offset. A backward branch (negative offset) is guessed taken and a forward branch is guessed not taken. It then drives the select of the next-PC multiplexer, so the guessed path is fetched in the very next cycle. Direct jumps always steer to the target computed by the external adder.

Each guess is written into a one-entry record together with the fallthrough and taken-target addresses supplied by the fetch-stage adders. One cycle later the branch sits in decode and the comparator outcome arrives. If it disagrees with the guess, the block raises a single-cycle mispredict pulse. The pipeline control uses this pulse to turn the wrong-path instruction into a no-op: its memory and write-back enables are cleared and its branch signal is masked, but it still moves down the pipe. In the same cycle the block overrides the multiplexer select to redirect fetch, and it presents the correct address from the record. A redirect always beats a guess made in the same cycle, and the instruction being fetched then is never tracked.

Top module: `branch_dir_predictor`

## Requirements
- R1: When no redirect is active, a fetch class of 2'b00 (other) or 2'b11 (unused) gives pc_sel = 2'b00 (sequential, PC + 4) in the same cycle.
- R2: A fetch class of 2'b01 (conditional branch) with fetch_off_neg = 1 gives pc_sel = 2'b01 (guessed target) in the same cycle, unless a redirect is active.
- R3: A conditional branch with fetch_off_neg = 0 gives pc_sel = 2'b00 in the same cycle, unless a redirect is active.
- R4: A fetch class of 2'b10 (direct jump) gives pc_sel = 2'b01 in the same cycle, unless a redirect is active, and the jump is not tracked.
- R5: In the cycle after a tracked branch was fetched, mispredict is high exactly when dec_cmp_taken differs from the guess. The pulse lasts one cycle.
- R6: When a taken guess resolves not taken, pc_sel = 2'b10 and redir_pc equals the fallthrough address that fetch_fall carried in the branch's fetch cycle.
- R7: When a not-taken guess resolves taken, pc_sel = 2'b11 and redir_pc equals the target address that fetch_tgt carried in the branch's fetch cycle.
- R8: In a cycle with a redirect, the redirect select wins over any fetch-stage guess. An instruction fetched in that cycle is not tracked, so the next cycle shows no mispredict whatever dec_cmp_taken is.
- R9: While rst_n is low, pc_sel is 2'b00 and mispredict is low for any input values.
- R10: dec_cmp_taken has no effect on any output when no branch was tracked in the previous cycle.
- R11: redir_pc is zero in every cycle without a redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fetch_class | input | 2 | Pre-decode class: 00 other, 01 conditional branch, 10 direct jump, 11 unused |
| fetch_off_neg | input | 1 | Sign bit of the branch offset (1 = backward) |
| fetch_fall | input | AW | Fallthrough address (PC + 4) of the fetched instruction |
| fetch_tgt | input | AW | Taken-target address of the fetched instruction |
| dec_cmp_taken | input | 1 | Comparator outcome for the branch now in decode |
| pc_sel | output | 2 | Next-PC select: 00 sequential, 01 guessed target, 10 redirect to fallthrough, 11 redirect to target |
| redir_pc | output | AW | Correct-path address during a redirect, zero otherwise |
| mispredict | output | 1 | One-cycle pulse that flushes the wrong-path instruction |

## Verification
The guess for a fetched instruction is combinational, so pc_sel is due in the same cycle as the fetch inputs. The comparison, mispredict and redir_pc are due exactly one clock edge later, when the branch sits in decode. The bench drives inputs just after the falling edge and samples all outputs one nanosecond later, before the next rising edge. It keeps a behavioural record of the tracked branch that it updates only at the rising edge. Each comparison is therefore made against the record of the previous cycle, with the two-edge internal reset release taken into account. A ten-pass backward loop confirms that only the exit produces a pulse.

// File: rtl/bdp_pkg.sv
package bdp_pkg;

  typedef enum logic [1:0] {
    CLS_OTHER  = 2'b00,
    CLS_BRANCH = 2'b01,
    CLS_JUMP   = 2'b10,
    CLS_UNUSED = 2'b11
  } fetch_cls_e;

  typedef enum logic [1:0] {
    SEL_SEQ      = 2'b00,
    SEL_GUESS    = 2'b01,
    SEL_FIX_FALL = 2'b10,
    SEL_FIX_TGT  = 2'b11
  } next_sel_e;

endpackage

// File: rtl/bdp_rst_sync.sv
module bdp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/bdp_guess.sv
module bdp_guess
  import bdp_pkg::*;
(
  input  fetch_cls_e cls_i,
  input  logic       off_neg_i,
  output logic       is_cond_o,
  output logic       guess_tk_o,
  output next_sel_e  sel_o
);

  always_comb begin
    is_cond_o  = 1'b0;
    guess_tk_o = 1'b0;
    sel_o      = SEL_SEQ;
    unique case (cls_i)
      CLS_BRANCH: begin
        is_cond_o  = 1'b1;
        guess_tk_o = off_neg_i;
        sel_o      = off_neg_i ? SEL_GUESS : SEL_SEQ;
      end
      CLS_JUMP:   sel_o = SEL_GUESS;
      default:    sel_o = SEL_SEQ;
    endcase
  end

endmodule

// File: rtl/bdp_track.sv
module bdp_track #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_i,
  input  logic          guess_i,
  input  logic [AW-1:0] fall_i,
  input  logic [AW-1:0] tgt_i,
  output logic          vld_o,
  output logic          guess_o,
  output logic [AW-1:0] fall_o,
  output logic [AW-1:0] tgt_o
);

  logic          vld_q, vld_d;
  logic          guess_q, guess_d;
  logic [AW-1:0] fall_q, fall_d;
  logic [AW-1:0] tgt_q, tgt_d;

  always_comb begin
    vld_d   = cap_i;
    guess_d = guess_i;
    fall_d  = fall_i;
    tgt_d   = tgt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      guess_q <= 1'b0;
      fall_q  <= '0;
      tgt_q   <= '0;
    end else if (cap_i) begin
      guess_q <= guess_d;
      fall_q  <= fall_d;
      tgt_q   <= tgt_d;
    end
  end

  assign vld_o   = vld_q;
  assign guess_o = guess_q;
  assign fall_o  = fall_q;
  assign tgt_o   = tgt_q;

  AST_CAPTURE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && !cap_i) |=> ($stable(fall_o) && $stable(tgt_o))) else $error("capture lost"); // R6

endmodule

// File: rtl/bdp_resolve.sv
module bdp_resolve
  import bdp_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          vld_i,
  input  logic          guess_i,
  input  logic          cmp_i,
  input  logic [AW-1:0] fall_i,
  input  logic [AW-1:0] tgt_i,
  output logic          miss_o,
  output next_sel_e     fix_sel_o,
  output logic [AW-1:0] fix_pc_o
);

  always_comb begin
    miss_o    = vld_i && (cmp_i != guess_i);
    fix_sel_o = SEL_SEQ;
    fix_pc_o  = '0;
    if (miss_o) begin
      if (guess_i) begin
        fix_sel_o = SEL_FIX_FALL;
        fix_pc_o  = fall_i;
      end else begin
        fix_sel_o = SEL_FIX_TGT;
        fix_pc_o  = tgt_i;
      end
    end
  end

endmodule

// File: rtl/branch_dir_predictor.sv
module branch_dir_predictor
  import bdp_pkg::*;
#(
  parameter int AW        = 32,
  parameter int RST_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    fetch_class,
  input  logic          fetch_off_neg,
  input  logic [AW-1:0] fetch_fall,
  input  logic [AW-1:0] fetch_tgt,
  input  logic          dec_cmp_taken,
  output logic [1:0]    pc_sel,
  output logic [AW-1:0] redir_pc,
  output logic          mispredict
);

  logic          rst_q_n;
  fetch_cls_e    cls;
  logic          is_cond, guess_tk;
  next_sel_e     guess_sel, fix_sel, sel;
  logic          trk_vld, trk_guess;
  logic [AW-1:0] trk_fall, trk_tgt, fix_pc;
  logic          miss, cap;

  bdp_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_q_n)
  );

  assign cls = fetch_cls_e'(fetch_class);

  bdp_guess u_guess (
    .cls_i(cls), .off_neg_i(fetch_off_neg),
    .is_cond_o(is_cond), .guess_tk_o(guess_tk), .sel_o(guess_sel)
  );

  // a redirect discards the guess made in the same cycle
  assign cap = is_cond && !miss && rst_q_n;

  bdp_track #(.AW(AW)) u_track (
    .clk(clk), .rst_n(rst_q_n), .cap_i(cap), .guess_i(guess_tk),
    .fall_i(fetch_fall), .tgt_i(fetch_tgt),
    .vld_o(trk_vld), .guess_o(trk_guess), .fall_o(trk_fall), .tgt_o(trk_tgt)
  );

  bdp_resolve #(.AW(AW)) u_resolve (
    .vld_i(trk_vld), .guess_i(trk_guess), .cmp_i(dec_cmp_taken),
    .fall_i(trk_fall), .tgt_i(trk_tgt),
    .miss_o(miss), .fix_sel_o(fix_sel), .fix_pc_o(fix_pc)
  );

  always_comb begin
    if (!rst_q_n)  sel = SEL_SEQ;
    else if (miss) sel = fix_sel;
    else           sel = guess_sel;
  end

  assign pc_sel     = sel;
  assign redir_pc   = fix_pc;
  assign mispredict = miss;

  AST_OTHER_SEQ: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!mispredict && !fetch_class[0]  && !fetch_class[1]) |-> pc_sel == 2'b00) else $error("other"); // R1
  AST_BACKWARD_TAKEN: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!mispredict && fetch_class == 2'b01 && fetch_off_neg) |-> pc_sel == 2'b01) else $error("bwd"); // R2
  AST_FORWARD_SEQ: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!mispredict && fetch_class == 2'b01 && !fetch_off_neg) |-> pc_sel == 2'b00) else $error("fwd"); // R3
  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!mispredict && fetch_class == 2'b10) |=> !trk_vld) else $error("jump tracked"); // R4
  AST_MISS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_q_n)
    mispredict |=> !mispredict) else $error("pulse width"); // R5
  AST_REDIRECT_SEL: assert property (@(posedge clk) disable iff (!rst_q_n)
    mispredict == pc_sel[1]) else $error("redirect sel"); // R6
  AST_FLUSH_DROPS: assert property (@(posedge clk) disable iff (!rst_q_n)
    mispredict |=> !trk_vld) else $error("flush kept"); // R8
  AST_IDLE_NO_MISS: assert property (@(posedge clk) disable iff (!rst_q_n)
    !trk_vld |-> !mispredict) else $error("idle miss"); // R10
  AST_REDIR_ZERO: assert property (@(posedge clk) disable iff (!rst_q_n)
    !pc_sel[1] |-> redir_pc == '0) else $error("redir nonzero"); // R11

endmodule

// File: tb/tb_branch_dir_predictor.sv
`timescale 1ns/1ps
module tb_branch_dir_predictor;

  localparam int AW = 32;
  localparam logic [1:0] C_OTH = 2'b00, C_BR = 2'b01, C_JMP = 2'b10, C_UNU = 2'b11;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    fetch_class;
  logic          fetch_off_neg;
  logic [AW-1:0] fetch_fall, fetch_tgt;
  logic          dec_cmp_taken;
  logic [1:0]    pc_sel;
  logic [AW-1:0] redir_pc;
  logic          mispredict;

  int errors = 0, checks = 0, miss_seen = 0;
  bit done = 0;

  // behavioural record of the branch now in decode
  bit            m_vld = 0, m_guess = 0;
  logic [AW-1:0] m_fall = '0, m_tgt = '0;

  always #10 clk = ~clk;

  branch_dir_predictor #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .fetch_class(fetch_class), .fetch_off_neg(fetch_off_neg),
    .fetch_fall(fetch_fall), .fetch_tgt(fetch_tgt), .dec_cmp_taken(dec_cmp_taken),
    .pc_sel(pc_sel), .redir_pc(redir_pc), .mispredict(mispredict)
  );

  task automatic chk(input string tag, input string what, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input logic [1:0] cls, input logic neg, input logic cmp,
                      input logic [AW-1:0] fa, input logic [AW-1:0] ta, input string tag);
    bit exp_miss;
    logic [1:0] exp_sel;
    logic [AW-1:0] exp_pc;
    fetch_class = cls; fetch_off_neg = neg; dec_cmp_taken = cmp;
    fetch_fall = fa; fetch_tgt = ta;
    #1;
    exp_miss = m_vld && (cmp != m_guess);
    if (exp_miss)          exp_sel = m_guess ? 2'b10 : 2'b11;
    else if (cls == C_BR)  exp_sel = neg ? 2'b01 : 2'b00;
    else if (cls == C_JMP) exp_sel = 2'b01;
    else                   exp_sel = 2'b00;
    exp_pc = exp_miss ? (m_guess ? m_fall : m_tgt) : '0;
    chk(tag, "pc_sel", AW'(pc_sel), AW'(exp_sel));
    chk(tag, "mispredict", AW'(mispredict), AW'(exp_miss));
    chk(tag, "redir_pc", redir_pc, exp_pc);
    if (mispredict) miss_seen++;
    @(posedge clk);
    if (cls == C_BR && !exp_miss) begin
      m_vld = 1; m_guess = neg; m_fall = fa; m_tgt = ta;
    end else m_vld = 0;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    fetch_class = C_BR; fetch_off_neg = 1'b1; dec_cmp_taken = 1'b1;
    fetch_fall = 32'h104; fetch_tgt = 32'h0F0;
    repeat (3) @(negedge clk);
    #1;
    chk("R9", "pc_sel in reset", AW'(pc_sel), '0);
    chk("R9", "mispredict in reset", AW'(mispredict), '0);
    @(negedge clk);
    rst_n = 1'b1;
    fetch_class = C_OTH; dec_cmp_taken = 1'b0;
    repeat (3) @(negedge clk);

    step(C_OTH, 0, 0, 32'h204, 32'h300, "R1");
    step(C_UNU, 1, 0, 32'h208, 32'h300, "R1");
    step(C_BR,  1, 0, 32'h20C, 32'h100, "R2");
    step(C_OTH, 0, 1, 32'h104, 32'h200, "R5");
    step(C_BR,  0, 0, 32'h108, 32'h400, "R3");
    step(C_OTH, 0, 0, 32'h10C, 32'h500, "R5");
    step(C_JMP, 0, 0, 32'h110, 32'h600, "R4");
    step(C_OTH, 0, 1, 32'h604, 32'h700, "R10");
    step(C_OTH, 1, 1, 32'h608, 32'h700, "R10");
    // not-taken guess resolves taken
    step(C_BR,  0, 0, 32'h60C, 32'hA00, "R7");
    step(C_OTH, 0, 1, 32'h610, 32'hB00, "R7");
    step(C_OTH, 0, 1, 32'hA04, 32'hB00, "R5");
    // taken guess resolves not taken
    step(C_BR,  1, 0, 32'hA08, 32'h900, "R6");
    step(C_OTH, 0, 0, 32'h904, 32'h980, "R6");
    step(C_OTH, 0, 0, 32'hA0C, 32'h980, "R11");
    // redirect collides with a new backward guess
    step(C_BR,  0, 0, 32'hA10, 32'hC00, "R8");
    step(C_BR,  1, 1, 32'hA14, 32'hD00, "R8");
    step(C_OTH, 0, 0, 32'hC04, 32'hE00, "R8");
    step(C_OTH, 0, 1, 32'hC08, 32'hE00, "R8");
    // back-to-back branches
    step(C_BR,  1, 0, 32'hC0C, 32'h800, "R2");
    step(C_BR,  1, 1, 32'h804, 32'h700, "R5");
    step(C_OTH, 0, 0, 32'h704, 32'h000, "R6");

    // ten-pass loop closed by a backward branch
    miss_seen = 0;
    for (int i = 0; i < 10; i++) begin
      step(C_BR,  1, 0, 32'h1040, 32'h1000, "R2");
      step(C_OTH, 0, (i < 9), 32'h1004, 32'h2000, "R5");
    end
    chk("R5", "loop mispredict count", AW'(miss_seen), 32'd1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule